// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of a small 8-bit processor core that has a 16-bit address space. It shares one 8-bit group of pins between the low address byte and the data byte. The core hands the sequencer one request at a time: an opcode fetch, a memory read, a memory write, an I/O read or an I/O write, with an address and, for writes, a data byte. The sequencer then steps through clock-period states. In the first state it puts the address out and pulses a latch strobe, so that external logic can hold the low byte. It then turns the shared pins over to data, asserts the active-low read or write strobe, and stretches the cycle with wait states for as long as the slow-device input stays low. It captures the returned byte on reads and flags the final state of the cycle.

Each cycle carries status lines for its whole length. One line separates memory from I/O. A two-bit code names the cycle class, and its idle value means halt. An opcode fetch takes one extra decode state after the data state, so it runs four states where the other cycles run three. While no cycle is running, every address and data driver is released.

Top module: `busseq_top`

## Requirements
- R1: While rst_n is low and in the cycle after it rises with no request, the block is idle: ale=0, rd_n=1, wr_n=1, io_m=0, status=00, addr_hi_oe=0, ad_oe=0, done=0, and rd_data=0.
- R2: A request is taken on a rising edge where req_valid=1 and the block is idle. The next clock period is the first state. In that state ale=1, ad_oe=1 and addr_hi_oe=1. For memory kinds, ad_out is req_addr[7:0] and addr_hi is req_addr[15:8]. ale is high for exactly that one period.
- R3: req_kind encodes 0=opcode fetch, 1=memory read, 2=memory write, 3=I/O read and 4=I/O write. From the first state to the last state of a cycle, io_m is 1 for kinds 3 and 4 and 0 otherwise. Over the same span, status is 11 for fetch, 10 for reads and 01 for writes, and it does not change within the cycle.
- R4: For fetch and read kinds, rd_n is low from the second state through the data state, and ad_oe is 0 from the second state onward. The byte on ad_in is captured at the end of the data state. It appears on rd_data from the next period and is kept until the next read-type cycle.
- R5: For write kinds, wr_n is low and ad_oe=1 with ad_out=req_wdata from the second state through the data state. rd_n stays high and rd_data is unchanged.
- R6: With ready held high, a fetch lasts 4 periods and every other kind lasts 3. done is 1 only in the final period, which is the decode state for a fetch and the data state otherwise.
- R7: ready is sampled at the end of the second state and at the end of each wait state. Every low sample inserts one more wait period that keeps the second-state strobes and drivers, with done=0.
- R8: For I/O kinds, the 8-bit port number req_addr[7:0] is driven on ad_out in the first state and on addr_hi for the whole cycle. req_addr[15:8] is not used.
- R9: A req_valid while a cycle is running is ignored: the running cycle's outputs do not change, and no new cycle starts after it. A req_kind of 5, 6 or 7 is ignored even when the block is idle.
- R10: In idle, status=00, addr_hi_oe=0 and ad_oe=0. An rst_n low in the middle of a cycle returns the block to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one period per bus state |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_kind | input | 3 | Cycle kind (0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write) |
| req_addr | input | 16 | Cycle address; low byte is the port number for I/O |
| req_wdata | input | 8 | Write data byte |
| ready | input | 1 | Slow-device input; low adds wait states |
| ad_in | input | 8 | Data returned on the shared pins |
| ale | output | 1 | Address latch strobe, first state only |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | 1 for I/O cycles, 0 for memory |
| status | output | 2 | Cycle class: 11 fetch, 10 read, 01 write, 00 halt |
| addr_hi | output | 8 | High address byte or mirrored port number |
| addr_hi_oe | output | 1 | Driver enable for addr_hi |
| ad_out | output | 8 | Shared-pin drive value: low address, then write data |
| ad_oe | output | 1 | Driver enable for ad_out |
| rd_data | output | 8 | Last captured read byte |
| done | output | 1 | High in the final state of a cycle |

## Verification
All five kinds are run with distinct addresses and data. Fetch against memory read tells the four-state cycle from the three-state one, memory against I/O tells apart the status lines and the mirrored port number, and read against write separates strobe choice, driver turnaround and capture. Wait counts of 0, 1, 2 and 3 show that each low ready sample adds exactly one held period. The read bus byte is changed right after the data state, which pins down the capture edge. Requests during a busy cycle, illegal kind codes and a reset mid-cycle show that no extra cycle starts and that the drivers are released.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

   typedef enum logic [2:0] {
      K_FETCH = 3'd0,
      K_MRD   = 3'd1,
      K_MWR   = 3'd2,
      K_IORD  = 3'd3,
      K_IOWR  = 3'd4
   } kind_t;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_T1   = 3'd1,
      S_T2   = 3'd2,
      S_TW   = 3'd3,
      S_T3   = 3'd4,
      S_T4   = 3'd5
   } tstate_t;

   function automatic logic kind_ok(input logic [2:0] k);
      return k <= 3'd4;
   endfunction

   function automatic logic kind_io(input logic [2:0] k);
      return (k == K_IORD) || (k == K_IOWR);
   endfunction

   function automatic logic kind_wr(input logic [2:0] k);
      return (k == K_MWR) || (k == K_IOWR);
   endfunction

   function automatic logic [1:0] kind_status(input logic [2:0] k);
      case (k)
         K_FETCH:       return 2'b11;
         K_MRD, K_IORD: return 2'b10;
         K_MWR, K_IOWR: return 2'b01;
         default:       return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/busseq_tstate.sv
module busseq_tstate
   import busseq_pkg::*;
#(
   parameter int DECODE_STATES = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    is_fetch,
   input  logic    ready,
   output tstate_t state,
   output logic    done
);

   localparam logic HAS_DEC = (DECODE_STATES > 0);

   initial begin : elab_chk
      assert (DECODE_STATES >= 0 && DECODE_STATES <= 16)
         else $error("DECODE_STATES out of range");
   end

   tstate_t nxt;
   logic    dec_last;

   generate
      if (DECODE_STATES > 1) begin : g_cnt
         localparam int CW = $clog2(DECODE_STATES);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (state != S_T4) cnt <= '0;
            else                    cnt <= cnt + 1'b1;
         end
         assign dec_last = (cnt == CW'(DECODE_STATES - 1));
      end else begin : g_one
         assign dec_last = 1'b1;
      end
   endgenerate

   always_comb begin
      nxt = state;
      unique case (state)
         S_IDLE:     if (start) nxt = S_T1;
         S_T1:       nxt = S_T2;
         S_T2, S_TW: nxt = ready ? S_T3 : S_TW;
         S_T3:       nxt = (is_fetch && HAS_DEC) ? S_T4 : S_IDLE;
         S_T4:       if (dec_last) nxt = S_IDLE;
         default:    nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_IDLE;
      else        state <= nxt;
   end

   assign done = ((state == S_T3) && !(is_fetch && HAS_DEC)) ||
                 ((state == S_T4) && dec_last);

   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == S_T2 || state == S_TW) && !ready) |=> (state == S_TW)); // R7

   AST_START_T1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state == S_IDLE) |=> (state == S_T1)); // R2

endmodule

// File: rtl/busseq_datapath.sv
module busseq_datapath
   import busseq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  tstate_t           state,
   input  logic [DATA_W-1:0] ad_in,
   output logic [2:0]        cur_kind,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_kind  <= K_FETCH;
         cur_addr  <= '0;
         cur_wdata <= '0;
      end else if (start) begin
         cur_kind  <= req_kind;
         cur_addr  <= req_addr;
         cur_wdata <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (state == S_T3 && !kind_wr(cur_kind))
         rd_data <= ad_in;
   end

   AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(cur_addr) && $stable(cur_kind)); // R9

endmodule

// File: rtl/busseq_drive.sv
module busseq_drive
   import busseq_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter bit IO_MIRROR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  tstate_t                  state,
   input  logic [2:0]               cur_kind,
   input  logic [ADDR_W-1:0]        cur_addr,
   input  logic [DATA_W-1:0]        cur_wdata,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     io_m,
   output logic [1:0]               status,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic                     addr_hi_oe,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe
);

   localparam int HI_W = ADDR_W - DATA_W;

   initial begin : elab_chk
      assert (HI_W > 0) else $error("ADDR_W must exceed DATA_W");
      assert (!IO_MIRROR || HI_W == DATA_W) else $error("port mirroring needs equal halves");
   end

   logic            active, is_io, is_wr, strobe_win;
   logic [HI_W-1:0] hi_mem, hi_io;

   assign active     = (state != S_IDLE);
   assign is_io      = kind_io(cur_kind);
   assign is_wr      = kind_wr(cur_kind);
   assign strobe_win = (state == S_T2) || (state == S_TW) || (state == S_T3);
   assign hi_mem     = cur_addr[ADDR_W-1:DATA_W];

   generate
      if (IO_MIRROR) begin : g_mirror
         assign hi_io = HI_W'(cur_addr[DATA_W-1:0]);
      end else begin : g_zero
         assign hi_io = '0;
      end
   endgenerate

   assign ale        = (state == S_T1);
   assign rd_n       = !(strobe_win && !is_wr);
   assign wr_n       = !(strobe_win && is_wr);
   assign io_m       = active && is_io;
   assign status     = active ? kind_status(cur_kind) : 2'b00;
   assign addr_hi_oe = active;
   assign addr_hi    = !active ? '0 : (is_io ? hi_io : hi_mem);
   assign ad_oe      = (state == S_T1) || (strobe_win && is_wr);
   assign ad_out     = (state == S_T1) ? cur_addr[DATA_W-1:0] : cur_wdata;

   AST_ALE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale); // R2

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n)); // R4

   AST_HIZ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_hi_oe |-> (!ad_oe && status == 2'b00 && rd_n && wr_n)); // R10

   AST_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_hi_oe && $past(addr_hi_oe)) |-> ($stable(status) && $stable(io_m))); // R3

endmodule

// File: rtl/busseq_top.sv
module busseq_top
   import busseq_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int DECODE_STATES = 1,
   parameter bit IO_MIRROR     = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [2:0]               req_kind,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic                     ready,
   input  logic [DATA_W-1:0]        ad_in,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     io_m,
   output logic [1:0]               status,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic                     addr_hi_oe,
   output logic [DATA_W-1:0]        ad_out,
   output logic                     ad_oe,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     done
);

   tstate_t           state;
   logic              start;
   logic [2:0]        cur_kind;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_wdata;

   assign start = req_valid && (state == S_IDLE) && kind_ok(req_kind);

   busseq_tstate #(.DECODE_STATES(DECODE_STATES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_fetch (cur_kind == K_FETCH),
      .ready    (ready),
      .state    (state),
      .done     (done)
   );

   busseq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .req_kind  (req_kind),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .state     (state),
      .ad_in     (ad_in),
      .cur_kind  (cur_kind),
      .cur_addr  (cur_addr),
      .cur_wdata (cur_wdata),
      .rd_data   (rd_data)
   );

   busseq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_MIRROR(IO_MIRROR)) u_drv (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .cur_kind   (cur_kind),
      .cur_addr   (cur_addr),
      .cur_wdata  (cur_wdata),
      .ale        (ale),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .io_m       (io_m),
      .status     (status),
      .addr_hi    (addr_hi),
      .addr_hi_oe (addr_hi_oe),
      .ad_out     (ad_out),
      .ad_oe      (ad_oe)
   );

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !ale)); // R6

endmodule

// File: tb/tb_busseq_top.sv
`timescale 1ns/1ps
module tb_busseq_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic        ready = 1'b1;
   logic [7:0]  ad_in = 8'h0;
   logic        ale, rd_n, wr_n, io_m, addr_hi_oe, ad_oe, done;
   logic [1:0]  status;
   logic [7:0]  addr_hi, ad_out, rd_data;

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] last_rd = 8'h00;

   always #5 clk = ~clk;

   busseq_top dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .ad_in(ad_in),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .status(status),
      .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe),
      .rd_data(rd_data), .done(done)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk({tag, " ale"}, 16'(ale), 16'd0);
      chk({tag, " strobes"}, {14'd0, rd_n, wr_n}, 16'd3);
      chk({tag, " status"}, 16'(status), 16'd0);
      chk({tag, " io_m"}, 16'(io_m), 16'd0);
      chk({tag, " oe"}, {14'd0, addr_hi_oe, ad_oe}, 16'd0);
      chk({tag, " done"}, 16'(done), 16'd0);
   endtask

   function automatic logic [1:0] exp_status(input logic [2:0] k);
      case (k)
         3'd0:       return 2'b11;
         3'd1, 3'd3: return 2'b10;
         default:    return 2'b01;
      endcase
   endfunction

   // One full bus cycle of kind k with nwait low ready samples.
   task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] rv, input int nwait);
      logic io, wr;
      logic [7:0] lo, hi;
      logic [1:0] st;
      io = (k == 3'd3) || (k == 3'd4);
      wr = (k == 3'd2) || (k == 3'd4);
      lo = a[7:0];
      hi = io ? a[7:0] : a[15:8];
      st = exp_status(k);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      // first state: R2, R3, R8
      chk("R2 T1 ale", 16'(ale), 16'd1);
      chk("R2 T1 oe", {14'd0, addr_hi_oe, ad_oe}, 16'd3);
      chk(io ? "R8 T1 port low" : "R2 T1 addr low", 16'(ad_out), 16'(lo));
      chk(io ? "R8 T1 port high" : "R2 T1 addr high", 16'(addr_hi), 16'(hi));
      chk("R3 T1 status", 16'(status), 16'(st));
      chk("R3 T1 io_m", 16'(io_m), 16'(io));
      chk("R2 T1 strobes idle", {14'd0, rd_n, wr_n}, 16'd3);
      @(negedge clk);
      // second state
      ad_in = rv;
      chk("R2 T2 ale low", 16'(ale), 16'd0);
      if (wr) begin
         chk("R5 T2 wr_n", {14'd0, rd_n, wr_n}, 16'd2);
         chk("R5 T2 data", {7'd0, ad_oe, ad_out}, {7'd0, 1'b1, wd});
      end else begin
         chk("R4 T2 rd_n", {14'd0, rd_n, wr_n}, 16'd1);
         chk("R4 T2 ad released", 16'(ad_oe), 16'd0);
      end
      chk("R6 T2 not done", 16'(done), 16'd0);
      ready = (nwait == 0);
      for (int i = 0; i < nwait; i++) begin
         @(negedge clk);
         chk("R7 wait strobes held", {14'd0, rd_n, wr_n}, wr ? 16'd2 : 16'd1);
         chk("R7 wait not done", 16'(done), 16'd0);
         chk("R7 wait status", 16'(status), 16'(st));
         chk("R8 wait high byte", 16'(addr_hi), 16'(hi));
         if (wr) chk("R5 wait data", {7'd0, ad_oe, ad_out}, {7'd0, 1'b1, wd});
         ready = (i == nwait - 1);
      end
      @(negedge clk);
      // data state
      chk("R4 R5 T3 strobes", {14'd0, rd_n, wr_n}, wr ? 16'd2 : 16'd1);
      chk("R6 T3 done", 16'(done), (k == 3'd0) ? 16'd0 : 16'd1);
      chk("R3 T3 status", 16'(status), 16'(st));
      if (wr) chk("R5 T3 data", {7'd0, ad_oe, ad_out}, {7'd0, 1'b1, wd});
      @(posedge clk);
      #1 ad_in = ~rv;
      if (!wr) last_rd = rv;
      if (k == 3'd0) begin
         @(negedge clk);
         chk("R6 T4 done", 16'(done), 16'd1);
         chk("R4 T4 rd_n high", {14'd0, rd_n, wr_n}, 16'd3);
         chk("R4 T4 ad released", 16'(ad_oe), 16'd0);
         chk("R3 T4 status", 16'(status), 16'd3);
         chk("R4 T4 captured", 16'(rd_data), 16'(rv));
      end
      @(negedge clk);
      chk_idle("R10 after cycle");
      chk(wr ? "R5 rd_data unchanged" : "R4 rd_data", 16'(rd_data), 16'(last_rd));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk_idle("R1 in reset");
      chk("R1 rd_data", 16'(rd_data), 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1 after reset");
   endtask

   task automatic t_busy_ignore();
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h4000; ready = 1'b1;
      @(negedge clk);
      req_kind = 3'd4; req_addr = 16'hABCD;
      @(negedge clk);
      chk("R9 busy high byte", 16'(addr_hi), 16'h40);
      chk("R9 busy status", 16'(status), 16'd2);
      chk("R9 busy io_m", 16'(io_m), 16'd0);
      @(negedge clk);
      chk("R9 busy done", 16'(done), 16'd1);
      req_valid = 1'b0;
      @(negedge clk);
      chk_idle("R9 no extra cycle");
      @(negedge clk);
      chk("R9 no late ale", 16'(ale), 16'd0);
      last_rd = ad_in;
   endtask

   task automatic t_bad_kind();
      for (int k = 5; k < 8; k++) begin
         @(negedge clk);
         req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h1234;
         @(negedge clk);
         req_valid = 1'b0;
         chk_idle("R9 bad kind");
      end
   endtask

   task automatic t_reset_mid();
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h5555; req_wdata = 8'h77;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R10 mid write active", 16'(wr_n), 16'd0);
      rst_n = 1'b0;
      #1;
      chk_idle("R10 reset mid cycle");
      @(negedge clk);
      rst_n = 1'b1;
      last_rd = 8'h00;
      @(negedge clk);
      chk_idle("R10 after mid reset");
      chk("R1 rd_data cleared", 16'(rd_data), 16'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      t_reset();
      run_cycle(3'd0, 16'h800F, 8'h00, 8'hDB, 0);
      run_cycle(3'd1, 16'h8850, 8'h00, 8'h3A, 2);
      run_cycle(3'd2, 16'h4004, 8'hCC, 8'h11, 0);
      run_cycle(3'd3, 16'h1280, 8'h00, 8'h5C, 0);
      run_cycle(3'd4, 16'hFE42, 8'h99, 8'h22, 1);
      run_cycle(3'd0, 16'h9050, 8'h00, 8'hC3, 3);
      t_busy_ignore();
      t_bad_kind();
      t_reset_mid();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule